// File: doc/BRIEF.md
# Pipelined zero-turnaround synchronous SRAM

This block is a synthesizable model of a single-clock synchronous static RAM. It accepts a new read or write command on every rising clock edge. Switching from reading to writing, or back, costs no idle cycle. Every command input is captured on the rising edge. Read data leaves through an output register, so it appears two edges after its command. Write data is taken two edges after its command, in the slot where read data would otherwise sit. The shared data bus therefore carries one transfer per clock in either direction.

A command either loads a new address or advances a 2-bit burst counter from the loaded address. The burst follows interleaved or linear order. Writes can be masked per 9-bit byte lane. Three chip enables allow several devices to share one bus for depth expansion. A sleep input freezes the whole block without losing any stored data. The tri-state data bus is split into an input, an output and an output-enable signal. The output enable is also gated without a clock by an output-enable pin.

Top module: `zbt_sram`

## Requirements
- R1: A read load on edge k makes `data_oe_o` high between edge k+1 and edge k+2, with `data_o` holding the word stored at the read address. This holds when `oe_ni`=0 and `sleep_i`=0. A read load is `adv_i`=0, the device selected and `we_i`=0.
- R2: A write load on edge k (`adv_i`=0, selected, `we_i`=1) takes `data_i` on edge k+2. During the slot between edge k+1 and edge k+2, `data_oe_o` is low. Reads and writes may follow each other on consecutive edges in any mix.
- R3: A read issued on the edge right after a write to the same address returns the newly written lanes.
- R4: Lane i is `data_i[9i+8:9i]`. During a write, lane i is stored only if `lane_we_ni[i]`=0 on that command's edge. Every other lane keeps its old contents.
- R5: A load selects the device only when `ce1_ni`=0, `ce2_i`=1 and `ce3_ni`=0. In every other case the load is a deselect cycle. A deselect cycle writes nothing, and `data_oe_o` stays low in its slot.
- R6: An advance (`adv_i`=1) that follows a deselect cycle has no effect. It writes nothing, drives no data, and leaves the block deselected.
- R7: On an advance, the burst counter steps by one modulo 4 and repeats the previous command type. The chip enables are not looked at. If `lin_i`=0 at the load, address bits [1:0] are the start bits XOR the count. The upper address bits keep the loaded value.
- R8: If `lin_i`=1 at the load, address bits [1:0] are the start bits plus the count, modulo 4.
- R9: While `sleep_i`=1, commands are ignored and no register changes. `data_oe_o` is low and the stored data is kept. Once `sleep_i` returns to 0, operation resumes from the held pipeline state.
- R10: `oe_ni`=1 forces `data_oe_o` low at once, with no clock edge needed.
- R11: While `rst_ni`=0, `data_oe_o` is low and any command in flight is dropped. The first advance after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | AW | Word address used on a load |
| adv_i | input | 1 | 1 = advance burst, 0 = load new command |
| we_i | input | 1 | 1 = write, 0 = read, on a load |
| lane_we_ni | input | LANES | Per-lane write enable, active low |
| ce1_ni | input | 1 | Chip enable, active low |
| ce2_i | input | 1 | Chip enable, active high |
| ce3_ni | input | 1 | Chip enable, active low |
| lin_i | input | 1 | Burst order on a load: 1 linear, 0 interleaved |
| sleep_i | input | 1 | Sleep: freeze all state |
| oe_ni | input | 1 | Output enable, active low, unclocked |
| data_i | input | LANES*LW | Write data from the bus |
| data_o | output | LANES*LW | Read data to the bus |
| data_oe_o | output | 1 | Bus driver enable |

## Verification
The most likely faults in this block are a wrong burst count, a stale stage-one address, or a write that misses its forwarding path. Each of these shows up as a wrong word on `data_o` in the slot two edges after the read command. A lost or extra write, or a mis-masked lane, stays hidden until that address is read again. For this reason every run ends by reading the whole array back. A frozen or unfrozen pipeline around sleep shifts `data_oe_o` by one slot, and that shift is visible within two edges of the sleep change.

// File: rtl/zbt_pkg.sv
`timescale 1ns/1ps
package zbt_pkg;
  typedef enum logic [1:0] {OP_IDLE = 2'd0, OP_RD = 2'd1, OP_WR = 2'd2} op_e;
  localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/zbt_burst_seq.sv
`timescale 1ns/1ps
module zbt_burst_seq #(
  parameter int unsigned CW = 2
) (
  input  logic [CW-1:0] base_i,
  input  logic [CW-1:0] cnt_i,
  input  logic          lin_i,
  output logic [CW-1:0] off_o
);
  always_comb begin
    if (lin_i) off_o = base_i + cnt_i;
    else       off_o = base_i ^ cnt_i;
  end
endmodule

// File: rtl/zbt_cmd_stage.sv
`timescale 1ns/1ps
module zbt_cmd_stage
  import zbt_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hold_i,
  input  logic             adv_i,
  input  logic             we_i,
  input  logic             sel_i,
  input  logic             lin_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [LANES-1:0] lane_we_ni,
  output op_e              op_o,
  output logic [AW-1:0]    addr_o,
  output logic [LANES-1:0] mask_o
);
  localparam int unsigned CW = BURST_W;

  op_e              op_q;
  logic [AW-1:0]    base_q;
  logic [CW-1:0]    cnt_q;
  logic             lin_q;
  logic [LANES-1:0] mask_q;
  logic [CW-1:0]    off;

  // stage-one register doubles as the burst state
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      cnt_q  <= '0;
      lin_q  <= 1'b0;
      mask_q <= '0;
    end else if (!hold_i) begin
      mask_q <= ~lane_we_ni;
      if (!adv_i) begin
        cnt_q <= '0;
        if (sel_i) begin
          op_q   <= we_i ? OP_WR : OP_RD;
          base_q <= addr_i;
          lin_q  <= lin_i;
        end else begin
          op_q <= OP_IDLE;
        end
      end else if (op_q != OP_IDLE) begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  zbt_burst_seq #(.CW(CW)) u_seq (
    .base_i (base_q[CW-1:0]),
    .cnt_i  (cnt_q),
    .lin_i  (lin_q),
    .off_o  (off)
  );

  assign op_o   = op_q;
  assign addr_o = {base_q[AW-1:CW], off};
  assign mask_o = mask_q;
endmodule

// File: rtl/zbt_array.sv
`timescale 1ns/1ps
module zbt_array #(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4,
  parameter int unsigned LW    = 9
) (
  input  logic                clk_i,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [LANES-1:0]    wr_mask_i,
  input  logic [LANES*LW-1:0] wr_data_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [LANES*LW-1:0] rd_data_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned DW    = LANES * LW;

  logic [DW-1:0] mem [DEPTH];
  logic          fwd;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int l = 0; l < LANES; l++) begin
        if (wr_mask_i[l]) mem[wr_addr_i][l*LW +: LW] <= wr_data_i[l*LW +: LW];
      end
    end
  end

  // commit and read share an edge: bypass the lanes being written
  assign fwd = wr_en_i && (wr_addr_i == rd_addr_i);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_data_o[g*LW +: LW] = (fwd && wr_mask_i[g]) ? wr_data_i[g*LW +: LW]
                                                         : mem[rd_addr_i][g*LW +: LW];
  end
endmodule

// File: rtl/zbt_sram.sv
`timescale 1ns/1ps
module zbt_sram
  import zbt_pkg::*;
#(
  parameter int unsigned AW    = 6,
  parameter int unsigned LANES = 4,
  parameter int unsigned LW    = 9
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [AW-1:0]       addr_i,
  input  logic                adv_i,
  input  logic                we_i,
  input  logic [LANES-1:0]    lane_we_ni,
  input  logic                ce1_ni,
  input  logic                ce2_i,
  input  logic                ce3_ni,
  input  logic                lin_i,
  input  logic                sleep_i,
  input  logic                oe_ni,
  input  logic [LANES*LW-1:0] data_i,
  output logic [LANES*LW-1:0] data_o,
  output logic                data_oe_o
);
  localparam int unsigned DW = LANES * LW;

  logic             sel;
  op_e              s1_op, s2_op;
  logic [AW-1:0]    s1_addr, s2_addr;
  logic [LANES-1:0] s1_mask, s2_mask;
  logic             wr_en;
  logic [DW-1:0]    rd_data;
  logic [DW-1:0]    dout_q;

  assign sel = !ce1_ni && ce2_i && !ce3_ni;

  zbt_cmd_stage #(.AW(AW), .LANES(LANES)) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hold_i     (sleep_i),
    .adv_i      (adv_i),
    .we_i       (we_i),
    .sel_i      (sel),
    .lin_i      (lin_i),
    .addr_i     (addr_i),
    .lane_we_ni (lane_we_ni),
    .op_o       (s1_op),
    .addr_o     (s1_addr),
    .mask_o     (s1_mask)
  );

  assign wr_en = (s2_op == OP_WR) && !sleep_i;

  zbt_array #(.AW(AW), .LANES(LANES), .LW(LW)) u_mem (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (s2_addr),
    .wr_mask_i (s2_mask),
    .wr_data_i (data_i),
    .rd_addr_i (s1_addr),
    .rd_data_o (rd_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_op   <= OP_IDLE;
      s2_addr <= '0;
      s2_mask <= '0;
      dout_q  <= '0;
    end else if (!sleep_i) begin
      s2_op   <= s1_op;
      s2_addr <= s1_addr;
      s2_mask <= s1_mask;
      if (s1_op == OP_RD) dout_q <= rd_data;
    end
  end

  assign data_o    = dout_q;
  assign data_oe_o = (s2_op == OP_RD) && !oe_ni && !sleep_i;
endmodule

// File: rtl/zbt_sram_chk.sv
`timescale 1ns/1ps
module zbt_sram_chk #(
  parameter int unsigned DW = 36
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          adv_i,
  input logic          we_i,
  input logic          ce1_ni,
  input logic          ce2_i,
  input logic          ce3_ni,
  input logic          sleep_i,
  input logic          oe_ni,
  input logic [DW-1:0] data_o,
  input logic          data_oe_o
);
  logic [1:0] age;
  logic       on, ld_rd, ld_wr, ld_off, adv_c, aged;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  assign aged   = (age == 2'd3);
  assign on     = !ce1_ni && ce2_i && !ce3_ni;
  assign ld_rd  = !sleep_i && !adv_i && on && !we_i;
  assign ld_wr  = !sleep_i && !adv_i && on && we_i;
  assign ld_off = !sleep_i && !adv_i && !on;
  assign adv_c  = !sleep_i && adv_i;

  // R1
  rd_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aged && $past(ld_rd, 2) && $past(!sleep_i) && !oe_ni && !sleep_i |-> data_oe_o);

  // R2
  wr_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aged && $past(ld_wr, 2) && $past(!sleep_i) |-> !data_oe_o);

  // R5
  desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aged && $past(ld_off, 2) && $past(!sleep_i) |-> !data_oe_o);

  // R6
  adv_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aged && $past(ld_off, 3) && $past(adv_c, 2) && $past(!sleep_i) |-> !data_oe_o);

  // R9
  sleep_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |-> !data_oe_o);

  // R9
  sleep_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> $stable(data_o));

  // R10
  oe_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_ni |-> !data_oe_o);

  // R11
  always_comb begin
    if (!rst_ni) reset_off_chk: assert (!data_oe_o);
  end
endmodule

bind zbt_sram zbt_sram_chk #(.DW(DW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .adv_i     (adv_i),
  .we_i      (we_i),
  .ce1_ni    (ce1_ni),
  .ce2_i     (ce2_i),
  .ce3_ni    (ce3_ni),
  .sleep_i   (sleep_i),
  .oe_ni     (oe_ni),
  .data_o    (data_o),
  .data_oe_o (data_oe_o)
);

// File: tb/tb_zbt_sram.sv
`timescale 1ns/1ps
module tb_zbt_sram;
  localparam int AW = 6, LANES = 4, LW = 9, DW = LANES * LW, DEPTH = 1 << AW;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic adv_i = 1'b0, we_i = 1'b0, ce1_ni = 1'b1, ce2_i = 1'b0, ce3_ni = 1'b1;
  logic lin_i = 1'b0, sleep_i = 1'b0, oe_ni = 1'b0;
  logic [LANES-1:0] lane_we_ni = '1;
  logic [DW-1:0] data_i = '0;
  logic [DW-1:0] data_o;
  logic data_oe_o;

  zbt_sram #(.AW(AW), .LANES(LANES), .LW(LW)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .adv_i(adv_i), .we_i(we_i),
    .lane_we_ni(lane_we_ni), .ce1_ni(ce1_ni), .ce2_i(ce2_i), .ce3_ni(ce3_ni),
    .lin_i(lin_i), .sleep_i(sleep_i), .oe_ni(oe_ni), .data_i(data_i),
    .data_o(data_o), .data_oe_o(data_oe_o)
  );

  always #5 clk_i = ~clk_i;

  int n_tests = 0, n_fail = 0;
  string req = "R11";

  // reference model: command pipeline plus memory
  int p1_op = 0, p2_op = 0;           // 0 idle, 1 read, 2 write
  logic [AW-1:0] p1_base = '0, p2_addr = '0;
  logic [1:0] p1_cnt = '0;
  logic p1_lin = 1'b0;
  logic [LANES-1:0] p1_mask = '0, p2_mask = '0;
  logic e_vld = 1'b0;
  logic [DW-1:0] e_dat = '0;
  logic [DW-1:0] mem_m [DEPTH];

  function automatic logic [AW-1:0] p1_addr();
    logic [1:0] o;
    o = p1_lin ? p1_base[1:0] + p1_cnt : p1_base[1:0] ^ p1_cnt;
    return {p1_base[AW-1:2], o};
  endfunction

  task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic adv, input logic we, input logic c1n, input logic c2,
                      input logic c3n, input logic [LANES-1:0] lwen, input logic [AW-1:0] a,
                      input logic lin, input logic slp);
    logic [63:0] r;
    logic [DW-1:0] din;
    logic exp_oe;
    r = {$urandom(), $urandom()};
    din = r[DW-1:0];
    adv_i = adv; we_i = we; ce1_ni = c1n; ce2_i = c2; ce3_ni = c3n;
    lane_we_ni = lwen; addr_i = a; lin_i = lin; sleep_i = slp; data_i = din;
    @(posedge clk_i);
    if (!slp) begin
      if (p2_op == 2)
        for (int l = 0; l < LANES; l++)
          if (p2_mask[l]) mem_m[p2_addr][l*LW +: LW] = din[l*LW +: LW];
      e_vld = (p1_op == 1);
      if (e_vld) e_dat = mem_m[p1_addr()];
      p2_op = p1_op; p2_addr = p1_addr(); p2_mask = p1_mask;
      p1_mask = ~lwen;
      if (!adv) begin
        p1_cnt = '0;
        if (!c1n && c2 && !c3n) begin
          p1_op = we ? 2 : 1; p1_base = a; p1_lin = lin;
        end else p1_op = 0;
      end else if (p1_op != 0) p1_cnt = p1_cnt + 2'd1;
    end
    @(negedge clk_i);
    exp_oe = e_vld && !oe_ni && !slp;
    chk("output enable", {{(DW-1){1'b0}}, data_oe_o}, {{(DW-1){1'b0}}, exp_oe});
    if (exp_oe) chk("read data", data_o, e_dat);
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [LANES-1:0] lwen, input logic lin);
    step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, lwen, a, lin, 1'b0);
  endtask
  task automatic rd(input logic [AW-1:0] a, input logic lin);
    step(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, '1, a, lin, 1'b0);
  endtask
  task automatic advs(input logic [LANES-1:0] lwen);
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, lwen, '0, 1'b0, 1'b0);
  endtask
  task automatic nop();
    step(1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, '0, 1'b0, 1'b0);
  endtask

  task automatic rand_step(input logic allow_sleep);
    logic c1n;
    logic [LANES-1:0] lw;
    c1n = ($urandom_range(7) == 0);
    lw  = ($urandom_range(1) == 0) ? '0 : LANES'($urandom());
    step($urandom_range(3) == 0, $urandom_range(1) == 1, c1n, 1'b1, 1'b0, lw,
         AW'($urandom()), $urandom_range(1) == 1,
         allow_sleep && ($urandom_range(3) == 0));
  endtask

  task automatic model_reset();
    p1_op = 0; p2_op = 0; p1_cnt = '0; p1_mask = '0; p2_mask = '0; e_vld = 1'b0;
  endtask

  task automatic burst(input logic lin);
    logic [AW-1:0] b;
    for (int s = 0; s < 4; s++) begin
      b = {AW'($urandom()) >> 2, 2'(s)};
      wr(b, '0, lin);
      for (int k = 0; k < 5; k++) advs('0);        // wraps past four
      rd(b, lin);
      for (int k = 0; k < 7; k++) advs('1);
      nop();
    end
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R11: reset state
    req = "R11";
    repeat (3) @(negedge clk_i);
    chk("oe in reset", {{(DW-1){1'b0}}, data_oe_o}, '0);
    rst_ni = 1'b1;
    model_reset();
    advs('0); advs('0); nop();

    // R2: back-to-back writes fill the array
    req = "R2";
    for (int a = 0; a < DEPTH; a++) wr(AW'(a), '0, 1'b0);
    // R1: back-to-back reads right after the writes
    req = "R1";
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), 1'b0);
    nop(); nop();

    // R11: reset drops a read in flight
    req = "R11";
    rd(6'd3, 1'b0);
    rst_ni = 1'b0;
    model_reset();
    #1 chk("oe after reset", {{(DW-1){1'b0}}, data_oe_o}, '0);
    @(negedge clk_i); rst_ni = 1'b1;
    advs('1); advs('1); nop();

    // R3: write then read same address next edge
    req = "R3";
    for (int i = 0; i < 200; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom());
      wr(a, ($urandom_range(1) == 0) ? '0 : LANES'($urandom()), 1'b0);
      rd(a, 1'b0);
    end
    nop(); nop();

    // R2: random read/write mix, no gaps
    req = "R2";
    for (int i = 0; i < 400; i++)
      if ($urandom_range(1) == 0) wr(AW'($urandom()), '0, 1'b0);
      else rd(AW'($urandom()), 1'b0);
    nop(); nop();

    // R4: partial lane writes
    req = "R4";
    for (int i = 0; i < 300; i++)
      if ($urandom_range(1) == 0) wr(AW'($urandom()), LANES'($urandom()), 1'b0);
      else rd(AW'($urandom()), 1'b0);
    nop(); nop();

    // R5: every chip-enable combination
    req = "R5";
    for (int c = 0; c < 8; c++) begin
      step(1'b0, 1'b1, c[0], c[1], c[2], '0, 6'd5, 1'b0, 1'b0);
      step(1'b0, 1'b0, c[0], c[1], c[2], '1, 6'd5, 1'b0, 1'b0);
      nop();
      rd(6'd5, 1'b0);
      nop(); nop();
    end

    // R6: advance after deselect
    req = "R6";
    for (int i = 0; i < 20; i++) begin
      logic [AW-1:0] a;
      a = AW'($urandom());
      nop();
      step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, '0, a, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, '0, a, 1'b0, 1'b0);
      nop(); nop();
      rd(a, 1'b0); nop(); nop();
    end

    // R7 interleaved, R8 linear bursts
    req = "R7";
    burst(1'b0);
    req = "R8";
    burst(1'b1);
    nop(); nop();

    // R9: sleep periods in random traffic
    req = "R9";
    for (int i = 0; i < 600; i++) rand_step(1'b1);
    nop(); nop(); nop();

    // R10: unclocked output enable
    req = "R10";
    wr(6'd9, '0, 1'b0);
    rd(6'd9, 1'b0);
    nop();
    oe_ni = 1'b1;
    #1 chk("oe_ni high", {{(DW-1){1'b0}}, data_oe_o}, '0);
    oe_ni = 1'b0;
    #1 chk("oe_ni low", {{(DW-1){1'b0}}, data_oe_o}, {{(DW-1){1'b0}}, 1'b1});
    oe_ni = 1'b1;
    rd(6'd9, 1'b0); nop(); nop();
    oe_ni = 1'b0;
    nop();

    // R9: contents kept across all the above
    req = "R9";
    for (int a = 0; a < DEPTH; a++) rd(AW'(a), 1'b0);
    nop(); nop();

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule